// File: doc/BRIEF.md
# Dual-Clock Up/Down Binary Counter

This block is a reversible binary counter driven by two separate count strobes, one for counting up and one for counting down, instead of a single clock and a direction bit. Both strobes are asynchronous to the system clock. Each passes through a synchronizer and then an edge detector, and a detected rising edge steps the count. A master reset clears the count and a parallel load copies a data word into it. Each acts at the level of its input on every system clock, and neither waits for a count strobe.

Two active-low terminal-count outputs support cascading. The up terminal output goes low only at the top count, and only while the synchronized up strobe is low. The down terminal output goes low only at zero, and only while the synchronized down strobe is low. At a boundary state each output therefore copies the low phase of its strobe, so the outputs of one stage can drive the strobe inputs of the next stage directly. Defined behaviour needs at most one strobe low at a time. The block treats a violation as a fault: the count holds and an error pulse is raised.

Top module: `updn_dual_counter`

## Requirements
- R1: A rising edge of the synchronized up strobe while the synchronized down strobe is high (and no rising edge of the down strobe) adds one to the count, wrapping from all ones to 0.
- R2: A rising edge of the synchronized down strobe while the synchronized up strobe is high (and no rising edge of the up strobe) subtracts one from the count, wrapping from 0 to all ones.
- R3: While mreset_i is 1, the count becomes 0 at the next system clock edge. This overrides both strobes and a simultaneous load_n_i of 0.
- R4: While load_n_i is 0 and mreset_i is 0, the count becomes data_i at the next edge, whatever the strobes do.
- R5: tc_up_n_o is 0 only while the count is all ones and the synchronized up strobe is 0; otherwise it is 1.
- R6: tc_dn_n_o is 0 only while the count is 0 and the synchronized down strobe is 0; otherwise it is 1.
- R7: A strobe that is low during a reset or load and stays low afterwards is counted on its first rising edge after the release.
- R8: While both synchronized strobes are low, or both rise in the same cycle, the count holds. err_o is 1 for exactly one cycle at the start of each such episode.
- R9: With SYNC_STAGES = 2, a strobe change applied between clock edges reaches the terminal-count outputs at the second following edge and the count at the third following edge. mreset_i and load_n_i take effect at the first following edge.
- R10: Two instances chained, with each stage's tc_up_n_o and tc_dn_n_o driving the next stage's cnt_up_i and cnt_dn_i, form a 2*WIDTH-bit up/down counter that wraps at both ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for sampling and state |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cnt_up_i | input | 1 | Count-up strobe, asynchronous, idles high |
| cnt_dn_i | input | 1 | Count-down strobe, asynchronous, idles high |
| mreset_i | input | 1 | Master reset, active high, level-acting |
| load_n_i | input | 1 | Parallel load, active low, level-acting |
| data_i | input | WIDTH | Parallel load value |
| count_o | output | WIDTH | Current count |
| tc_up_n_o | output | 1 | Up terminal count, active low |
| tc_dn_n_o | output | 1 | Down terminal count, active low |
| err_o | output | 1 | One-cycle pulse when both strobes are illegal |

## Verification
A strobe edge changes the count three clock edges after it is applied and the terminal-count outputs two edges after it. The error pulse comes three edges after both strobes go low, and reset and load act one edge after they are applied. A bench model pushes every sampled strobe pair into a history queue and reads the synchronized level and the previous level back at those depths. The bench compares the count, both terminal outputs and the error pulse of the first stage on every falling clock edge, when the registered outputs are stable. Cascade checks on the combined 8-bit value are made only after each strobe pulse has had time to pass through both stages. Separate checks sample the count and the terminal outputs one cycle before and in the cycle each result is due.

// File: rtl/udc_pkg.sv
package udc_pkg;

  // Synchronized or raw levels of the two count strobes.
  typedef struct packed {
    logic up;
    logic dn;
  } udc_pair_t;

endpackage

// File: rtl/udc_sync.sv
module udc_sync #(
  parameter int              W       = 2,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        always_comb stg_d = d_i;
      end else begin : g_next
        always_comb stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/udc_edge.sv
module udc_edge
  import udc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  udc_pair_t lvl_i,
  output logic      inc_o,
  output logic      dec_o,
  output logic      illegal_o,
  output logic      err_o
);

  udc_pair_t prev_q;
  udc_pair_t rise;
  logic      ill_q;
  logic      err_q;
  logic      err_d;

  always_comb begin
    rise.up   = lvl_i.up & ~prev_q.up;
    rise.dn   = lvl_i.dn & ~prev_q.dn;
    inc_o     = rise.up & lvl_i.dn & ~rise.dn;
    dec_o     = rise.dn & lvl_i.up & ~rise.up;
    illegal_o = (~lvl_i.up & ~lvl_i.dn) | (rise.up & rise.dn);
    err_d     = illegal_o & ~ill_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      ill_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      ill_q  <= illegal_o;
      err_q  <= err_d;
    end
  end

  assign err_o = err_q;

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);

endmodule

// File: rtl/udc_core.sv
module udc_core #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mreset_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             illegal_i,
  output logic [WIDTH-1:0] count_o
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (mreset_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (!load_n_i) begin
      cnt_d  = data_i;
      cnt_en = 1'b1;
    end else if (inc_i) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end else if (dec_i) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R3
  mreset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreset_i |=> (cnt_q == '0));

  // R4
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreset_i && !load_n_i) |=> (cnt_q == $past(data_i)));

  // R1
  inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreset_i && load_n_i && inc_i) |=> (cnt_q == WIDTH'($past(cnt_q) + 1'b1)));

  // R2
  dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreset_i && load_n_i && dec_i) |=> (cnt_q == WIDTH'($past(cnt_q) - 1'b1)));

  // R8
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreset_i && load_n_i && illegal_i) |=> $stable(cnt_q));

endmodule

// File: rtl/udc_tc.sv
module udc_tc
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_i,
  input  udc_pair_t        lvl_i,
  output logic             tc_up_n_o,
  output logic             tc_dn_n_o
);

  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  always_comb begin
    tc_up_n_o = ~((count_i == CNT_MAX) & ~lvl_i.up);
    tc_dn_n_o = ~((count_i == '0)      & ~lvl_i.dn);
  end

endmodule

// File: rtl/updn_dual_counter.sv
module updn_dual_counter
  import udc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_up_i,
  input  logic             cnt_dn_i,
  input  logic             mreset_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_up_n_o,
  output logic             tc_dn_n_o,
  output logic             err_o
);

  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  udc_pair_t  raw;
  udc_pair_t  lvl;
  logic [1:0] lvl_vec;
  logic       inc;
  logic       dec;
  logic       illegal;

  assign raw = {cnt_up_i, cnt_dn_i};

  udc_sync #(
    .W      (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw),
    .q_o  (lvl_vec)
  );

  assign lvl = udc_pair_t'(lvl_vec);

  udc_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_i    (lvl),
    .inc_o    (inc),
    .dec_o    (dec),
    .illegal_o(illegal),
    .err_o    (err_o)
  );

  udc_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .mreset_i (mreset_i),
    .load_n_i (load_n_i),
    .data_i   (data_i),
    .inc_i    (inc),
    .dec_i    (dec),
    .illegal_i(illegal),
    .count_o  (count_o)
  );

  udc_tc #(.WIDTH(WIDTH)) u_tc (
    .count_i  (count_o),
    .lvl_i    (lvl),
    .tc_up_n_o(tc_up_n_o),
    .tc_dn_n_o(tc_dn_n_o)
  );

  // R5
  tc_up_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_up_n_o |-> (count_o == CNT_MAX));

  // R6
  tc_dn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_dn_n_o |-> (count_o == '0));

endmodule

// File: tb/updn_dual_counter_bench.sv
module updn_dual_counter_bench;

  logic       clk;
  logic       rst_n;
  logic       up, dn, mres, ld_n;
  logic [7:0] data8;
  logic [3:0] cnt_lo, cnt_hi;
  logic       tcu_lo, tcd_lo, err_lo;
  logic       tcu_hi, tcd_hi, err_hi;

  int checks   = 0;
  int failures = 0;
  int expv     = 0;
  bit done     = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  updn_dual_counter u_updn_dual_counter (
    .clk(clk), .rst_n(rst_n), .cnt_up_i(up), .cnt_dn_i(dn),
    .mreset_i(mres), .load_n_i(ld_n), .data_i(data8[3:0]),
    .count_o(cnt_lo), .tc_up_n_o(tcu_lo), .tc_dn_n_o(tcd_lo), .err_o(err_lo)
  );

  updn_dual_counter u_updn_dual_counter_hi (
    .clk(clk), .rst_n(rst_n), .cnt_up_i(tcu_lo), .cnt_dn_i(tcd_lo),
    .mreset_i(mres), .load_n_i(ld_n), .data_i(data8[7:4]),
    .count_o(cnt_hi), .tc_up_n_o(tcu_hi), .tc_dn_n_o(tcd_hi), .err_o(err_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Cycle model of the low stage: history queue of sampled strobe pairs.
  logic [1:0] hq [$];
  int m_cnt;
  bit m_ill_d, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq = {2'b11, 2'b11, 2'b11};
      m_cnt = 0; m_ill_d = 0; m_err = 0;
    end else begin
      logic [1:0] lv, ol;
      bit ru, rd, ill;
      lv = hq[1];
      ol = hq[2];
      ru = lv[1] & ~ol[1];
      rd = lv[0] & ~ol[0];
      ill = (lv == 2'b00) || (ru && rd);
      m_err = ill && !m_ill_d;
      m_ill_d = ill;
      if (mres) m_cnt = 0;
      else if (!ld_n) m_cnt = int'(data8[3:0]);
      else if (ru && lv[0] && !rd) m_cnt = (m_cnt + 1) % 16;
      else if (rd && lv[1] && !ru) m_cnt = (m_cnt + 15) % 16;
      hq.push_front({up, dn});
      void'(hq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e;
      e = {m_cnt[3:0],
           ~(m_cnt == 15 && !hq[1][1]),
           ~(m_cnt == 0  && !hq[1][0]),
           m_err};
      // R9 cycle timing of count, terminal outputs and error pulse
      chk("R9 cycle model {cnt,tcu,tcd,err}",
          int'({cnt_lo, tcu_lo, tcd_lo, err_lo}), e);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    up = 1'b0; wait_n(8); up = 1'b1; wait_n(10);
    expv = (expv + 1) % 256;
  endtask

  task automatic pulse_dn();
    dn = 1'b0; wait_n(8); dn = 1'b1; wait_n(10);
    expv = (expv + 255) % 256;
  endtask

  task automatic do_load(input logic [7:0] v);
    data8 = v; ld_n = 1'b0; wait_n(2); ld_n = 1'b1; wait_n(6);
    expv = int'(v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int errs;
    rst_n = 1'b0; up = 1'b1; dn = 1'b1; mres = 1'b0; ld_n = 1'b1; data8 = 8'h00;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk("R3 reset state combined", int'({cnt_hi, cnt_lo}), 0);
    chk("R5 tc_up idle", int'(tcu_lo), 1);
    chk("R6 tc_dn idle", int'(tcd_lo), 1);

    // R1 / R10: count up through a stage carry
    for (int i = 0; i < 20; i++) begin
      pulse_up();
      chk("R10 up chain", int'({cnt_hi, cnt_lo}), expv);
    end

    // R4 load, then R1 wrap of the full chain
    do_load(8'hFD);
    chk("R4 load value", int'({cnt_hi, cnt_lo}), 32'hFD);
    for (int i = 0; i < 5; i++) begin
      pulse_up();
      chk("R1 up wrap chain", int'({cnt_hi, cnt_lo}), expv);
    end

    // R2 down through zero
    for (int i = 0; i < 5; i++) begin
      pulse_dn();
      chk("R2 down wrap chain", int'({cnt_hi, cnt_lo}), expv);
    end

    // R4 load dominates a strobe pulse
    data8 = 8'h37; ld_n = 1'b0;
    up = 1'b0; wait_n(6); up = 1'b1; wait_n(6);
    ld_n = 1'b1; wait_n(8);
    chk("R4 load overrides strobes", int'({cnt_hi, cnt_lo}), 32'h37);

    // R3 reset overrides load
    data8 = 8'hA5; ld_n = 1'b0; mres = 1'b1; wait_n(3);
    chk("R3 reset over load", int'({cnt_hi, cnt_lo}), 0);
    mres = 1'b0; ld_n = 1'b1; wait_n(4);

    // R7 strobe low across a reset is counted after release
    up = 1'b0; wait_n(4);
    mres = 1'b1; wait_n(3); mres = 1'b0; wait_n(5);
    chk("R7 held during reset", int'({cnt_hi, cnt_lo}), 0);
    up = 1'b1; wait_n(10);
    chk("R7 counted after release", int'({cnt_hi, cnt_lo}), 1);
    expv = 1;

    // R8 both strobes low, then both rise together
    errs = 0;
    up = 1'b0; dn = 1'b0;
    for (int i = 0; i < 12; i++) begin wait_n(1); errs += int'(err_lo); end
    up = 1'b1; dn = 1'b1;
    for (int i = 0; i < 12; i++) begin wait_n(1); errs += int'(err_lo); end
    chk("R8 single error pulse", errs, 1);
    chk("R8 count held", int'({cnt_hi, cnt_lo}), 1);

    // R5 / R9 terminal-up timing at the top count
    do_load(8'h0F);
    up = 1'b0; wait_n(1);
    chk("R9 tc_up not yet low", int'(tcu_lo), 1);
    wait_n(1);
    chk("R5 tc_up low at top", int'(tcu_lo), 0);
    up = 1'b1; wait_n(10);
    chk("R10 carry into high stage", int'({cnt_hi, cnt_lo}), 32'h10);

    // R6 terminal-down at zero, borrow from high stage
    do_load(8'h10);
    dn = 1'b0; wait_n(3);
    chk("R6 tc_dn low at zero", int'(tcd_lo), 0);
    chk("R5 tc_up high off top", int'(tcu_lo), 1);
    dn = 1'b1; wait_n(10);
    chk("R10 borrow from high stage", int'({cnt_hi, cnt_lo}), 32'h0F);

    // R9 count latency of three edges
    do_load(8'h20);
    up = 1'b0; wait_n(8);
    up = 1'b1; wait_n(2);
    chk("R9 count unchanged after two edges", int'(cnt_lo), 0);
    wait_n(1);
    chk("R9 count stepped on third edge", int'(cnt_lo), 1);
    wait_n(10);

    finish_run();
  end

endmodule